// File: doc/BRIEF.md
# GPIO Controller with Interrupts

This block is a register-mapped general-purpose I/O controller serving up to 32 pins through a simple word-addressed bus made of valid, write, byte address, write data and a combinational read data return. Each pin has a direction bit, an output-enable bit and an output value register. Its input is passed through a two-flop synchronizer. Any pin can be handed to an alternate-function path, which then drives that pin's output and output enable in place of the registers.

Every pin can raise an interrupt. It can be level sensitive with a chosen polarity, or edge sensitive on a rising edge, a falling edge or both. Events are collected in a status register that clears itself when it is read, so no acknowledge register exists. A mask register is set and cleared through separate write-one strobes, and it gates the status onto a single combined interrupt line. Software reads status, services each set bit, and relies on level sources re-asserting on the following cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, direction, bypass and mask read all ones over the implemented pins. Status, type, value, any-edge, output enable and output value read zero, and irq is low.
- R2: Registers sit at byte offsets bypass 0x00, direction 0x04, output enable 0x08, output value 0x0C, input value 0x10, mask 0x14, enable strobe 0x18, disable strobe 0x1C, status 0x20, type 0x24, value 0x28 and any-edge 0x2C. Bits at or above NPINS read zero and ignore writes, and unmapped offsets read zero.
- R3: For a pin with bypass 0, pin_oe is 1 only when the direction bit is 0 (output) and the output-enable bit is 1. A direction bit of 1 (input) keeps pin_oe at 0.
- R4: For a pin with bypass 1, pin_out and pin_oe equal alt_out and alt_oe. With bypass 0, pin_out equals the output value register.
- R5: The output value register reads back the last value written, whatever the pins are doing. The input value register returns pin_in once it has passed two clock edges of synchronization.
- R6: Writing 1s to the enable strobe clears those mask bits, and writing 1s to the disable strobe sets them. Zero bits in the written word leave the mask unchanged.
- R7: irq is high exactly when some bit is set in status and clear in mask. A mask bit of 1 suppresses its pin.
- R8: A read of status returns the pending bits and clears all of them at that clock edge. An event detected in the same cycle as the read stays pending for the next read.
- R9: With type bit 1 the pin is level sensitive. Value bit 1 selects active-high and 0 selects active-low, and the status bit is set on every cycle that the synchronized level is active.
- R10: With type bit 0 the pin is edge sensitive. Value bit 1 selects rising and 0 selects falling, and an any-edge bit of 1 selects both edges. A pin's status bit is set three clock edges after pin_in changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| pin_in | input | NPINS | Pin input levels, asynchronous |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables |
| alt_out | input | NPINS | Alternate-function output values |
| alt_oe | input | NPINS | Alternate-function output enables |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench sweeps every pin through rising, falling and both-edge detection. A design that swapped the polarity meaning of the value bit, or let the any-edge bit be ignored, would set status on the wrong transition. It reads status back to back while a level source is active and across a change of level, which catches a design that cleared status after the new event was taken or that lost events between reads. It also checks mask strobes with zero bits, upper-bit writes with a reduced pin count and a partial bypass, so a mask that was rewritten rather than modified, a bit above the pin count that kept its value, or a mux that picked the wrong source would show on the ports.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  typedef enum logic [IDX_W-1:0] {
    SEL_BYPASS = 4'd0,
    SEL_DIR    = 4'd1,
    SEL_OE     = 4'd2,
    SEL_OUT    = 4'd3,
    SEL_IN     = 4'd4,
    SEL_MASK   = 4'd5,
    SEL_IEN    = 4'd6,
    SEL_IDIS   = 4'd7,
    SEL_STAT   = 4'd8,
    SEL_TYPE   = 4'd9,
    SEL_VAL    = 4'd10,
    SEL_ANY    = 4'd11
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] is_level,
  input  logic [W-1:0] polarity,
  input  logic [W-1:0] both_edges,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, level_hit;
    always_comb begin
      rise      = lvl[i] & ~prev_q[i];
      fall      = ~lvl[i] & prev_q[i];
      level_hit = polarity[i] ? lvl[i] : ~lvl[i];
      if (both_edges[i]) edge_hit = rise | fall;
      else               edge_hit = polarity[i] ? rise : fall;
      hit[i]    = is_level[i] ? level_hit : edge_hit;
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] bypass,
  input  logic [W-1:0] dir_in,
  input  logic [W-1:0] oe_reg,
  input  logic [W-1:0] out_reg,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (bypass[i]) begin
        pin_out[i] = alt_out[i];
        pin_oe[i]  = alt_oe[i];
      end else begin
        pin_out[i] = out_reg[i];
        pin_oe[i]  = oe_reg[i] & ~dir_in[i];
      end
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  alt_out,
  input  logic [NPINS-1:0]  alt_oe,
  output logic              irq
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IDX_W-1:0] sel;
  logic             wr_en, rd_stat;
  logic [NPINS-1:0] wd;

  assign sel     = bus_addr[ADDR_W-1:2];
  assign wr_en   = bus_valid & bus_write;
  assign rd_stat = bus_valid & ~bus_write & (sel == SEL_STAT);
  assign wd      = bus_wdata[NPINS-1:0];

  logic [NPINS-1:0] bypass_q, dir_q, oe_q, out_q, mask_q, status_q, type_q, val_q, any_q;
  logic [NPINS-1:0] bypass_d, dir_d, oe_d, out_d, mask_d, status_d, type_d, val_d, any_d;
  logic [NPINS-1:0] in_sync, hit;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .lvl        (in_sync),
    .is_level   (type_q),
    .polarity   (val_q),
    .both_edges (any_q),
    .hit        (hit)
  );

  gpio_pad_mux #(.W(NPINS)) u_mux (
    .bypass  (bypass_q),
    .dir_in  (dir_q),
    .oe_reg  (oe_q),
    .out_reg (out_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  // Next-state
  always_comb begin
    bypass_d = bypass_q;
    dir_d    = dir_q;
    oe_d     = oe_q;
    out_d    = out_q;
    mask_d   = mask_q;
    type_d   = type_q;
    val_d    = val_q;
    any_d    = any_q;
    if (wr_en) begin
      case (sel)
        SEL_BYPASS: bypass_d = wd;
        SEL_DIR:    dir_d    = wd;
        SEL_OE:     oe_d     = wd;
        SEL_OUT:    out_d    = wd;
        SEL_IEN:    mask_d   = mask_q & ~wd;
        SEL_IDIS:   mask_d   = mask_q | wd;
        SEL_TYPE:   type_d   = wd;
        SEL_VAL:    val_d    = wd;
        SEL_ANY:    any_d    = wd;
        default:    ;
      endcase
    end
    status_d = (rd_stat ? '0 : status_q) | hit;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bypass_q <= '1;
      dir_q    <= '1;
      oe_q     <= '0;
      out_q    <= '0;
      mask_q   <= '1;
      status_q <= '0;
      type_q   <= '0;
      val_q    <= '0;
      any_q    <= '0;
    end else begin
      bypass_q <= bypass_d;
      dir_q    <= dir_d;
      oe_q     <= oe_d;
      out_q    <= out_d;
      mask_q   <= mask_d;
      status_q <= status_d;
      type_q   <= type_d;
      val_q    <= val_d;
      any_q    <= any_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_BYPASS: bus_rdata[NPINS-1:0] = bypass_q;
      SEL_DIR:    bus_rdata[NPINS-1:0] = dir_q;
      SEL_OE:     bus_rdata[NPINS-1:0] = oe_q;
      SEL_OUT:    bus_rdata[NPINS-1:0] = out_q;
      SEL_IN:     bus_rdata[NPINS-1:0] = in_sync;
      SEL_MASK:   bus_rdata[NPINS-1:0] = mask_q;
      SEL_STAT:   bus_rdata[NPINS-1:0] = status_q;
      SEL_TYPE:   bus_rdata[NPINS-1:0] = type_q;
      SEL_VAL:    bus_rdata[NPINS-1:0] = val_q;
      SEL_ANY:    bus_rdata[NPINS-1:0] = any_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NPINS-1:0]  mask_q,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  bypass_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  alt_out,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq
);
  logic [IDX_W-1:0] sel;
  logic             wr_ien, wr_idis, wr_out, rd_st;
  assign sel     = bus_addr[ADDR_W-1:2];
  assign wr_ien  = bus_valid & bus_write & (sel == SEL_IEN);
  assign wr_idis = bus_valid & bus_write & (sel == SEL_IDIS);
  assign wr_out  = bus_valid & bus_write & (sel == SEL_OUT);
  assign rd_st   = bus_valid & ~bus_write & (sel == SEL_STAT);

  p_input_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q & ~bypass_q) == '0);

  p_bypass_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out ^ alt_out) & bypass_q) == '0);

  p_out_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out |=> out_q == $past(bus_wdata[NPINS-1:0]));

  p_mask_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (mask_q & $past(bus_wdata[NPINS-1:0])) == '0);

  p_mask_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idis |=> (mask_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]));

  p_all_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st |=> status_q == $past(hit));

  p_hit_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (status_q & $past(hit)) == $past(hit));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mask_q    (mask_q),
  .status_q  (status_q),
  .out_q     (out_q),
  .bypass_q  (bypass_q),
  .dir_q     (dir_q),
  .hit       (hit),
  .alt_out   (alt_out),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  localparam int NP = 8;
  localparam logic [31:0] FULL = 32'h0000_00FF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write;
  logic [5:0]    bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe, alt_out, alt_oe;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; alt_out = '0; alt_oe = '0;
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // R1 reset values
    rdchk("R1 bypass", 6'h00, FULL);
    rdchk("R1 dir",    6'h04, FULL);
    rdchk("R1 oe",     6'h08, 0);
    rdchk("R1 out",    6'h0C, 0);
    rdchk("R1 mask",   6'h14, FULL);
    rdchk("R1 status", 6'h20, 0);
    rdchk("R1 type",   6'h24, 0);
    rdchk("R1 value",  6'h28, 0);
    rdchk("R1 any",    6'h2C, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 upper bits and unmapped offsets
    wr(6'h0C, 32'hFFFF_FF5A);
    rdchk("R2 upper bits dropped", 6'h0C, 32'h5A);
    rdchk("R2 unmapped offset", 6'h30, 0);
    rdchk("R2 enable strobe offset reads zero", 6'h18, 0);

    // R4 full bypass after reset
    alt_out = 8'hA5; alt_oe = 8'h3C;
    tick(1);
    chk("R4 bypass out", {24'b0, pin_out}, 32'hA5);
    chk("R4 bypass oe",  {24'b0, pin_oe},  32'h3C);

    // R4 partial bypass: low nibble alternate, high nibble registers
    wr(6'h04, 32'h00);
    wr(6'h08, 32'hFF);
    wr(6'h0C, 32'h0F);
    wr(6'h00, 32'h0F);
    tick(1);
    chk("R4 mixed out", {24'b0, pin_out}, 32'h05);
    chk("R4 mixed oe",  {24'b0, pin_oe},  32'hFC);
    wr(6'h00, 32'h00);

    // R3 / R5 sweep over direction and output patterns
    for (int k = 0; k < 16; k++) begin
      logic [7:0] dv, ov, ev;
      dv = 8'(k * 17 + 3);
      ov = ~dv;
      ev = 8'(k * 29);
      wr(6'h04, {24'b0, dv});
      wr(6'h08, {24'b0, ev});
      wr(6'h0C, {24'b0, ov});
      tick(1);
      chk("R3 pin_oe", {24'b0, pin_oe}, {24'b0, ev & ~dv});
      chk("R4 pin_out from register", {24'b0, pin_out}, {24'b0, ov});
      rdchk("R5 out readback", 6'h0C, {24'b0, ov});
    end

    // R5 input synchronizer
    for (int k = 0; k < 8; k++) begin
      logic [7:0] pv;
      pv = 8'(k * 37 + 1);
      @(negedge clk);
      pin_in = pv;
      tick(2);
      rdchk("R5 input value", 6'h10, {24'b0, pv});
    end
    pin_in = '0;
    tick(3);

    // R6 mask strobes
    wr(6'h18, 32'h05);
    rdchk("R6 enable clears", 6'h14, 32'hFA);
    wr(6'h1C, 32'h01);
    rdchk("R6 disable sets", 6'h14, 32'hFB);
    wr(6'h18, 32'h00);
    rdchk("R6 zero enable no effect", 6'h14, 32'hFB);
    wr(6'h1C, 32'h00);
    rdchk("R6 zero disable no effect", 6'h14, 32'hFB);
    wr(6'h1C, 32'hFF);

    // R10 edge sweep: mode 0 rising, 1 falling, 2 both
    wr(6'h24, 32'h00);
    for (int m = 0; m < 3; m++) begin
      wr(6'h28, (m == 0) ? FULL : 32'h0);
      wr(6'h2C, (m == 2) ? FULL : 32'h0);
      for (int i = 0; i < NP; i++) begin
        tick(4);
        rd(6'h20, d);
        rd(6'h20, d);
        @(negedge clk);
        pin_in = 8'(1 << i);
        tick(4);
        rdchk("R10 rising edge", 6'h20, (m != 1) ? (32'h1 << i) : 32'h0);
        rdchk("R8 cleared after read", 6'h20, 0);
        @(negedge clk);
        pin_in = '0;
        tick(4);
        rdchk("R10 falling edge", 6'h20, (m != 0) ? (32'h1 << i) : 32'h0);
      end
    end
    wr(6'h2C, 32'h00);

    // R9 level: pins 0-3 active-high, 4-7 active-low
    wr(6'h28, 32'h0F);
    wr(6'h24, FULL);
    tick(3);
    rd(6'h20, d);
    rdchk("R9 active-low level", 6'h20, 32'hF0);
    rdchk("R8 level re-pends after read", 6'h20, 32'hF0);
    @(negedge clk);
    pin_in = 8'hFF;
    tick(4);
    rdchk("R8 pending kept across level change", 6'h20, 32'hFF);
    rdchk("R9 active-high level", 6'h20, 32'h0F);

    // R7 combined interrupt
    chk("R7 all masked", {31'b0, irq}, 0);
    wr(6'h18, 32'h10);
    tick(1);
    chk("R7 unmasked idle pin", {31'b0, irq}, 0);
    wr(6'h18, 32'h01);
    tick(1);
    chk("R7 unmasked active pin", {31'b0, irq}, 1);
    wr(6'h1C, 32'h01);
    tick(1);
    chk("R7 remasked", {31'b0, irq}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule